// File: doc/BRIEF.md
# Paged Card Configuration Register Controller

This block holds the two configuration registers that a removable flash card exposes in attribute space: an option register and a status register. It also turns the host's common-memory strobes into one chip enable per flash device pair, and drives a single reset/power-down line shared by all devices. A 2-bit page number in the option register extends the card beyond the 64MB that the host address can reach directly. Each page covers 64MB, made of two 32MB device pairs selected by the top address bit.

The host strobes are active-low and are sampled on the block clock. A register write takes effect at the clock edge where the write strobe is first seen high after being low. Chip enables, the access-allowed flag and the power-down line are combinational functions of the current strobes and the stored register state.

Setting the soft-reset bit of the option register powers the array down and blocks every memory access. Clearing the bit returns the card to its default state. Page value 3 is a dead page: no device answers in it. A card with two pairs or fewer has no paging. The `NUM_PAIRS` parameter sets how many pairs are populated.

Top module: `cardcfg_pager`

## Requirements
- R1: While `rst` is high, `dev_pwrdn` is 1, `mem_ok` is 0 and no pair enable is asserted. After `rst` falls, both registers read 0x00 and `mem_ok` is 1.
- R2: The option register is selected only when `reg_n` and `ce1_n` are both low and `addr` equals exactly 0x4000. The status register is selected under the same strobes at exactly 0x4002. A write under any other strobe or address combination changes no register.
- R3: A register write takes effect at the clock edge where `we_n` is sampled high after being sampled low at the previous edge. Address and data are taken from that edge, and the new state is visible on the outputs from that edge onward. While `we_n` stays low, no register changes.
- R4: An option write with data bit 7 = 1 enters soft reset. It sets option bit 7, clears the page to 00 and clears the status power-down bit. While soft reset is active, `dev_pwrdn` is 1, `mem_ok` is 0 and status writes are ignored.
- R5: An option write with data bit 7 = 0 while soft reset is active ends soft reset. The page is left at 00 whatever data bits 1:0 hold.
- R6: Outside soft reset, an option write with bit 7 = 0 loads the page from data bits 1:0. When the page p is 0, 1 or 2, a common-memory cycle asserts the pair enable whose index is 2*p plus `addr[ADDR_W-1]`.
- R7: With page 3 (bits 1:0 = 11), `mem_ok` is 0 and no pair enable is asserted. The option register still reads back 0x03.
- R8: A status write sets power-down from data bit 2. While it is 1, `dev_pwrdn` is 1, `mem_ok` is 0 and no pair enable is asserted. Writing 0 restores normal access.
- R9: A pair enable with an index of `NUM_PAIRS` or more is never asserted. When `NUM_PAIRS` is 2 or less, page bits are never stored (they read 0) and the pair index is `addr[ADDR_W-1]` alone.
- R10: `rdata` carries a register image only when `reg_n`, `ce1_n` and `oe_n` are all low and the address selects a register. The option image has soft reset in bit 7 and the page in bits 1:0. The status image has power-down in bit 2. All other bits are 0, and `rdata` is 0x00 at all other times.
- R11: A pair enable is asserted only during a common-memory cycle, which is `reg_n` high with `ce1_n` or `ce2_n` low. At most one pair enable is asserted at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Hardware reset, active high, synchronous; also powers the array down |
| reg_n | input | 1 | Attribute-space select, active low |
| ce1_n | input | 1 | Even-byte card enable, active low |
| ce2_n | input | 1 | Odd-byte card enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; a register write takes effect on its rising edge |
| addr | input | ADDR_W | Host byte address |
| din | input | 8 | Low data byte from the host |
| rdata | output | 8 | Register readback byte |
| pair_en | output | NUM_PAIRS | One-hot chip enable per device pair, active high |
| dev_pwrdn | output | 1 | Reset/power-down line to every flash device |
| mem_ok | output | 1 | The array may currently be accessed |

## Verification
The enables, `mem_ok`, `dev_pwrdn` and `rdata` depend combinationally on the strobes and the stored state. They are therefore due in the same cycle as the strobe pattern that produces them. A register write is due one edge later: at the clock edge where the raised write strobe is first sampled. The bench drives its inputs one nanosecond after a rising edge and compares all outputs with its model at the following falling edge, so every comparison lands after the state that should produce the result has settled. One directed test holds the write strobe low for several cycles and probes the power-down line both before and after the edge that completes the write. This pins the write latency to exactly one edge.

// File: rtl/cardcfg_pkg.sv
package cardcfg_pkg;

    localparam int PAGE_W       = 2;
    localparam int SRST_BIT     = 7;
    localparam int PD_BIT       = 2;
    localparam int PAIR_IDX_W   = PAGE_W + 1;
    localparam logic [PAGE_W-1:0] PAGE_DEAD = 2'b11;
    localparam logic [15:0] OPT_OFFSET  = 16'h4000;
    localparam logic [15:0] STAT_OFFSET = 16'h4002;

    typedef struct packed {
        logic              srst;
        logic [PAGE_W-1:0] page;
        logic              pwrdn;
    } cfg_regs_t;

    typedef enum logic [1:0] {
        HC_IDLE   = 2'd0,
        HC_ATTR   = 2'd1,
        HC_COMMON = 2'd2
    } host_cyc_e;

    function automatic host_cyc_e classify(input logic reg_n, input logic ce1_n,
                                           input logic ce2_n);
        host_cyc_e k;
        if (ce1_n && ce2_n) k = HC_IDLE;
        else if (!reg_n)    k = HC_ATTR;
        else                k = HC_COMMON;
        return k;
    endfunction

    function automatic logic [7:0] opt_image(input cfg_regs_t r);
        logic [7:0] v;
        v = '0;
        v[SRST_BIT]      = r.srst;
        v[PAGE_W-1:0]    = r.page;
        return v;
    endfunction

    function automatic logic [7:0] stat_image(input cfg_regs_t r);
        logic [7:0] v;
        v = '0;
        v[PD_BIT] = r.pwrdn;
        return v;
    endfunction

endpackage

// File: rtl/cardcfg_regs.sv
module cardcfg_regs
    import cardcfg_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter bit PAGED  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output cfg_regs_t         regs
);

    localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_OFFSET);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFSET);

    logic we_q;
    logic wr_evt;
    logic sel_opt;
    logic sel_stat;
    logic unused_din;

    assign unused_din = ^{din[6:3]};
    assign wr_evt   = !we_q && we_n;
    assign sel_opt  = !reg_n && !ce1_n && (addr == OPT_A);
    assign sel_stat = !reg_n && !ce1_n && (addr == STAT_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            regs <= '0;
        end else begin
            we_q <= we_n;
            if (wr_evt && sel_opt) begin
                if (din[SRST_BIT]) begin
                    regs.srst  <= 1'b1;
                    regs.page  <= '0;
                    regs.pwrdn <= 1'b0;
                end else if (regs.srst) begin
                    regs <= '0;
                end else begin
                    regs.page <= PAGED ? din[PAGE_W-1:0] : '0;
                end
            end else if (wr_evt && sel_stat && !regs.srst) begin
                regs.pwrdn <= din[PD_BIT];
            end
        end
    end

endmodule

// File: rtl/cardcfg_readmux.sv
module cardcfg_readmux
    import cardcfg_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  cfg_regs_t         regs,
    output logic [7:0]        rdata
);

    localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_OFFSET);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFSET);

    logic rd_cycle;

    assign rd_cycle = !reg_n && !ce1_n && !oe_n;

    always_comb begin
        rdata = 8'h00;
        if (rd_cycle) begin
            if (addr == OPT_A)       rdata = opt_image(regs);
            else if (addr == STAT_A) rdata = stat_image(regs);
        end
    end

endmodule

// File: rtl/cardcfg_pairdec.sv
module cardcfg_pairdec
    import cardcfg_pkg::*;
#(
    parameter int NUM_PAIRS = 6,
    parameter bit PAGED     = 1'b1
) (
    input  host_cyc_e         cyc,
    input  logic              ok,
    input  logic [PAGE_W-1:0] page,
    input  logic              addr_msb,
    output logic [NUM_PAIRS-1:0] pair_en
);

    logic [PAIR_IDX_W-1:0] idx;
    logic                  go;

    generate
        if (PAGED) begin : g_paged
            assign idx = {page, addr_msb};
        end else begin : g_flat
            logic unused_page;
            assign unused_page = ^page;
            assign idx = {{PAGE_W{1'b0}}, addr_msb};
        end
    endgenerate

    assign go = (cyc == HC_COMMON) && ok;

    generate
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
            assign pair_en[i] = go && (idx == PAIR_IDX_W'(i));
        end
    endgenerate

endmodule

// File: rtl/cardcfg_pager.sv
module cardcfg_pager
    import cardcfg_pkg::*;
#(
    parameter int ADDR_W    = 26,
    parameter int NUM_PAIRS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_n,
    input  logic                 ce1_n,
    input  logic                 ce2_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           din,
    output logic [7:0]           rdata,
    output logic [NUM_PAIRS-1:0] pair_en,
    output logic                 dev_pwrdn,
    output logic                 mem_ok
);

    localparam bit PAGED = (NUM_PAIRS > 2);

    cfg_regs_t regs;
    host_cyc_e cyc;
    logic      dead_page;

    cardcfg_regs #(.ADDR_W(ADDR_W), .PAGED(PAGED)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .reg_n (reg_n),
        .ce1_n (ce1_n),
        .we_n  (we_n),
        .addr  (addr),
        .din   (din),
        .regs  (regs)
    );

    cardcfg_readmux #(.ADDR_W(ADDR_W)) u_rmux (
        .reg_n (reg_n),
        .ce1_n (ce1_n),
        .oe_n  (oe_n),
        .addr  (addr),
        .regs  (regs),
        .rdata (rdata)
    );

    assign cyc       = classify(reg_n, ce1_n, ce2_n);
    assign dead_page = PAGED && (regs.page == PAGE_DEAD);
    assign dev_pwrdn = rst || regs.srst || regs.pwrdn;
    assign mem_ok    = !dev_pwrdn && !dead_page;

    cardcfg_pairdec #(.NUM_PAIRS(NUM_PAIRS), .PAGED(PAGED)) u_dec (
        .cyc      (cyc),
        .ok       (mem_ok),
        .page     (regs.page),
        .addr_msb (addr[ADDR_W-1]),
        .pair_en  (pair_en)
    );

endmodule

// File: rtl/cardcfg_checks.sv
module cardcfg_checks #(
    parameter int ADDR_W    = 26,
    parameter int NUM_PAIRS = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_n,
    input logic                 ce1_n,
    input logic                 oe_n,
    input logic                 we_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [7:0]           din,
    input logic [7:0]           rdata,
    input logic [NUM_PAIRS-1:0] pair_en,
    input logic                 dev_pwrdn,
    input logic                 mem_ok
);

    localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(16'h4000);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(16'h4002);

    assert_reset_exit_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_ok && !dev_pwrdn));

    assert_srst_entry_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(we_n) && !reg_n && !ce1_n && addr == OPT_A && din[7])
        |=> (dev_pwrdn && !mem_ok));

    assert_pwrdn_write_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(we_n) && !reg_n && !ce1_n && addr == STAT_A && din[2])
        |=> dev_pwrdn);

    assert_blocked_no_enable_R7: assert property (@(posedge clk) disable iff (rst)
        !mem_ok |-> (pair_en == '0));

    assert_quiet_readback_R10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (rdata == 8'h00));

    assert_single_enable_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pair_en));

    assert_attr_no_enable_R11: assert property (@(posedge clk) disable iff (rst)
        !reg_n |-> (pair_en == '0));

endmodule

bind cardcfg_pager cardcfg_checks #(.ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_n     (reg_n),
    .ce1_n     (ce1_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .din       (din),
    .rdata     (rdata),
    .pair_en   (pair_en),
    .dev_pwrdn (dev_pwrdn),
    .mem_ok    (mem_ok)
);

// File: tb/test_cardcfg_pager.sv
module test_cardcfg_pager;

    localparam int AW = 26;
    localparam logic [AW-1:0] A_OPT  = 26'h0004000;
    localparam logic [AW-1:0] A_STAT = 26'h0004002;
    localparam logic [AW-1:0] A_LO   = 26'h0000100;
    localparam logic [AW-1:0] A_HI   = 26'h2000100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_n = 1'b1, ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;

    logic [7:0] rd0, rd1, rd2;
    logic [5:0] pe0;
    logic [4:0] pe1;
    logic [1:0] pe2;
    logic pd0, pd1, pd2, ok0, ok1, ok2;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;

    always #2 clk = ~clk;

    cardcfg_pager i_cardcfg_pager (
        .clk(clk), .rst(rst), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .rdata(rd0), .pair_en(pe0), .dev_pwrdn(pd0), .mem_ok(ok0));

    cardcfg_pager #(.NUM_PAIRS(5)) i_cardcfg_pager_p5 (
        .clk(clk), .rst(rst), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .rdata(rd1), .pair_en(pe1), .dev_pwrdn(pd1), .mem_ok(ok1));

    cardcfg_pager #(.NUM_PAIRS(2)) i_cardcfg_pager_p2 (
        .clk(clk), .rst(rst), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .rdata(rd2), .pair_en(pe2), .dev_pwrdn(pd2), .mem_ok(ok2));

    // behavioural model state, one entry per instance
    int np [3] = '{6, 5, 2};
    bit m_srst [3];
    int m_page [3];
    bit m_pd   [3];
    bit m_weq = 1'b1;

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                m_srst[k] = 0; m_page[k] = 0; m_pd[k] = 0;
            end
            m_weq = 1'b1;
        end else begin
            for (int k = 0; k < 3; k++) begin
                if (!m_weq && we_n && !reg_n && !ce1_n) begin
                    if (addr == A_OPT) begin
                        if (din[7]) begin
                            m_srst[k] = 1; m_page[k] = 0; m_pd[k] = 0;
                        end else if (m_srst[k]) begin
                            m_srst[k] = 0; m_page[k] = 0; m_pd[k] = 0;
                        end else begin
                            m_page[k] = (np[k] > 2) ? int'(din[1:0]) : 0;
                        end
                    end else if (addr == A_STAT && !m_srst[k]) begin
                        m_pd[k] = din[2];
                    end
                end
            end
            m_weq = we_n;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            int a_rd [3];
            int a_pe [3];
            int a_pd [3];
            int a_ok [3];
            a_rd = '{int'(rd0), int'(rd1), int'(rd2)};
            a_pe = '{int'(pe0), int'(pe1), int'(pe2)};
            a_pd = '{int'(pd0), int'(pd1), int'(pd2)};
            a_ok = '{int'(ok0), int'(ok1), int'(ok2)};
            for (int k = 0; k < 3; k++) begin
                int e_rd, e_pe, idx;
                bit e_pd, e_ok, common;
                e_rd = 0;
                if (!reg_n && !ce1_n && !oe_n) begin
                    if (addr == A_OPT)  e_rd = (m_srst[k] ? 128 : 0) + m_page[k];
                    if (addr == A_STAT) e_rd = m_pd[k] ? 4 : 0;
                end
                e_pd = rst || m_srst[k] || m_pd[k];
                e_ok = !e_pd && !(np[k] > 2 && m_page[k] == 3);
                common = reg_n && (!ce1_n || !ce2_n);
                idx = (np[k] > 2) ? (m_page[k] * 2 + int'(addr[AW-1])) : int'(addr[AW-1]);
                e_pe = (common && e_ok && idx < np[k]) ? (1 << idx) : 0;
                check(a_rd[k], e_rd, "R10 model rdata");
                check(a_pe[k], e_pe, "R6 model pair_en");
                check(a_pd[k], int'(e_pd), "R8 model dev_pwrdn");
                check(a_ok[k], int'(e_ok), "R7 model mem_ok");
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_bus();
        reg_n = 1; ce1_n = 1; ce2_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [7:0] d);
        step();
        reg_n = 0; ce1_n = 0; addr = a; din = d; we_n = 0;
        step();
        we_n = 1;
        step();
        idle_bus();
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, input int e0, input int e2,
                          input string tag);
        step();
        reg_n = 0; ce1_n = 0; oe_n = 0; addr = a;
        @(negedge clk);
        check(int'(rd0), e0, tag);
        check(int'(rd2), e2, tag);
        step();
        idle_bus();
    endtask

    task automatic mem_cyc(input logic [AW-1:0] a, input int e0, input int e1,
                           input int e2, input string tag);
        step();
        reg_n = 1; ce1_n = 0; ce2_n = 0; addr = a;
        @(negedge clk);
        check(int'(pe0), e0, tag);
        check(int'(pe1), e1, tag);
        check(int'(pe2), e2, tag);
        step();
        idle_bus();
    endtask

    initial begin
        #(4 * 50000);
        $display("FAIL watchdog: actual=running expected=finished");
        failures++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(int'(pd0), 1, "R1 pwrdn in reset");
        check(int'(ok0), 0, "R1 no access in reset");
        step();
        rst = 0;
        step();
        check(int'(ok0), 1, "R1 access after reset");
        rd_reg(A_OPT, 8'h00, 8'h00, "R1 option after reset");
        rd_reg(A_STAT, 8'h00, 8'h00, "R1 status after reset");

        mem_cyc(A_LO, 6'h01, 5'h01, 2'h1, "R6 page0 low pair");
        mem_cyc(A_HI, 6'h02, 5'h02, 2'h2, "R6 page0 high pair");

        wr_reg(A_OPT, 8'h01);
        rd_reg(A_OPT, 8'h01, 8'h00, "R9 page1 read, flat card keeps 0");
        mem_cyc(A_HI, 6'h08, 5'h08, 2'h2, "R6 page1 high pair; R9 flat card");

        wr_reg(A_OPT, 8'h02);
        mem_cyc(A_LO, 6'h10, 5'h10, 2'h1, "R6 page2 low pair");
        mem_cyc(A_HI, 6'h20, 5'h00, 2'h2, "R9 unpopulated pair stays off");

        wr_reg(A_OPT, 8'h03);
        rd_reg(A_OPT, 8'h03, 8'h00, "R7 dead page readback");
        mem_cyc(A_LO, 6'h00, 5'h00, 2'h1, "R7 dead page blocks enables");

        wr_reg(A_OPT, 8'h81);
        rd_reg(A_OPT, 8'h80, 8'h80, "R4 soft reset set, page cleared");
        check(int'(pd0), 1, "R4 pwrdn in soft reset");
        check(int'(ok0), 0, "R4 no access in soft reset");
        mem_cyc(A_LO, 6'h00, 5'h00, 2'h0, "R4 no enables in soft reset");
        wr_reg(A_STAT, 8'h04);
        rd_reg(A_STAT, 8'h00, 8'h00, "R4 status write ignored in soft reset");
        wr_reg(A_OPT, 8'h02);
        rd_reg(A_OPT, 8'h00, 8'h00, "R5 soft reset ends with page 00");
        check(int'(ok0), 1, "R5 access restored");

        wr_reg(A_STAT, 8'hFF);
        rd_reg(A_STAT, 8'h04, 8'h04, "R10 status unsupported bits zero");
        check(int'(pd0), 1, "R8 pwrdn set");
        mem_cyc(A_LO, 6'h00, 5'h00, 2'h0, "R8 no enables while powered down");
        wr_reg(A_STAT, 8'h00);
        check(int'(pd0), 0, "R8 pwrdn cleared");

        step();
        reg_n = 0; ce1_n = 1; ce2_n = 0; addr = A_OPT; din = 8'h02; we_n = 0;
        step(); we_n = 1; step(); idle_bus();
        rd_reg(A_OPT, 8'h00, 8'h00, "R2 odd-byte enable write ignored");
        step();
        reg_n = 1; ce1_n = 0; addr = A_OPT; din = 8'h02; we_n = 0;
        step(); we_n = 1; step(); idle_bus();
        rd_reg(A_OPT, 8'h00, 8'h00, "R2 common-space write ignored");
        wr_reg(26'h0004004, 8'h02);
        rd_reg(A_OPT, 8'h00, 8'h00, "R2 other address write ignored");
        wr_reg(26'h0104000, 8'h81);
        check(int'(pd0), 0, "R2 aliased address ignored");

        step();
        reg_n = 0; ce1_n = 0; oe_n = 1; addr = A_OPT;
        @(negedge clk);
        check(int'(rd0), 0, "R10 no output without oe");
        step(); idle_bus();

        step();
        reg_n = 0; ce1_n = 0; addr = A_STAT; din = 8'h04; we_n = 0;
        step(); step(); step();
        @(negedge clk);
        check(int'(pd0), 0, "R3 held strobe changes nothing");
        step();
        we_n = 1;
        @(negedge clk);
        check(int'(pd0), 0, "R3 not yet at strobe rise");
        @(negedge clk);
        check(int'(pd0), 1, "R3 applied at sampling edge");
        step(); idle_bus();

        step();
        reg_n = 1; ce1_n = 1; ce2_n = 0; addr = A_LO;
        @(negedge clk);
        check(int'(pe0), 0, "R11 blocked by pwrdn, odd cycle");
        step(); idle_bus();
        wr_reg(A_STAT, 8'h00);
        step();
        reg_n = 1; ce1_n = 1; ce2_n = 0; addr = A_LO;
        @(negedge clk);
        check(int'(pe0), 1, "R11 odd-byte common cycle enables");
        step(); idle_bus();

        wr_reg(A_OPT, 8'h01);
        step(); rst = 1;
        @(negedge clk);
        check(int'(pd0), 1, "R1 hardware reset powers down");
        step(); rst = 0;
        rd_reg(A_OPT, 8'h00, 8'h00, "R1 page cleared by hardware reset");

        repeat (3) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule